// File: doc/BRIEF.md
# High-Speed Negotiation Sequencer (Device Side)

This block runs on the device end of a serial bus link and decides, after every bus reset, whether the link will run at high speed. It watches the two-bit line state reported by the transceiver. On its own outputs it selects the termination, drives a chirp K, and raises a high-speed-enabled flag once the far end has answered with its own alternating K/J chirp.

A reset can reach the block in two ways. In the first, the block is still in full-speed mode and sees SE0, so it waits, sends its chirp K and then listens for the answer. In the second, the block is already in high-speed mode. There, an idle line and a reset look the same, so the block times a long SE0, drops back to full-speed termination and samples the line again. It chirps only if SE0 is still there. Otherwise it treats the event as a suspend and stays in full speed. If no valid answer arrives before the line returns to a steady J, the block stays in full speed and raises a fallback flag.

All time windows are given in nanoseconds and turned into clock cycles from a clock-frequency parameter in MHz. The default set-up is a 60 MHz clock.

Top module: `hs_chirp_seq`

## Requirements
- R1: While rst_n is low, term_hs, hs_en, tx_chirp_k and fs_fallback are all 0. Line encoding: 2'b00 = SE0, 2'b01 = J, 2'b10 = K.
- R2: In full-speed mode, SE0 held for at least 2.5 µs counts as a reset, and tx_chirp_k rises between 2.5 µs and 6 ms after the SE0 began.
- R3: tx_chirp_k stays high for at least 1 ms, and it falls no later than 7 ms after the SE0 that started the reset.
- R4: After the chirp, six alternating line states (K first, then J, K, J, K, J), each held at least 2.5 µs, switch term_hs and hs_en to 1 within 500 µs of the end of the sixth state. The sixth state ends when the line changes.
- R5: A hub answer with fewer than six valid states, or with states shorter than 2.5 µs, never sets hs_en.
- R6: While the block listens for the answer, J held longer than the debounce time (default 100 µs) returns the block to full-speed idle with fs_fallback = 1. fs_fallback clears when the next reset starts a chirp.
- R7: In high-speed mode, SE0 held continuously for 3.0 to 3.125 ms (default 3.05 ms) drops term_hs and hs_en to 0.
- R8: In high-speed mode, any K or J on the line restarts the SE0 timer, so regular line activity keeps hs_en at 1.
- R9: After the drop of R7, the line is sampled once, 100 to 875 µs later (default 300 µs). If it is SE0, tx_chirp_k rises at that point, and the chirp and answer then follow R3 and R4.
- R10: If the line is not SE0 at the sample point of R9, no chirp is sent. hs_en, term_hs and fs_fallback all stay 0.
- R11: In full-speed mode, an SE0 shorter than 2.5 µs does not start a chirp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency given by CLK_MHZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_st | input | 2 | Line state from the transceiver: 00 SE0, 01 J, 10 K |
| term_hs | output | 1 | 1 selects high-speed termination, 0 full-speed |
| hs_en | output | 1 | High-speed mode enabled |
| tx_chirp_k | output | 1 | Drive a chirp K onto the bus |
| fs_fallback | output | 1 | Last negotiation ended in full speed without a hub answer |

## Verification
The hardest case to reach is a reset that arrives while the block is already in high-speed mode. The only way into that mode through the ports is a complete and successful negotiation from full speed. After that, the line must stay SE0 for more than 3 ms, with no activity at all, before the revert-and-sample path starts. The scenario table is ordered so that every high-speed-origin row comes right after a row that ends in high speed. Each such row first sends short K/J bursts between long SE0 stretches, to show the timer restarts, and then holds SE0 long enough to force the revert. Its sample point then sees either SE0 or J, which covers both the reset branch and the suspend branch.

// File: rtl/hs_chirp_seq.sv
module hs_chirp_seq #(
  parameter int CLK_MHZ     = 60,
  parameter int T_DET_NS    = 2500,
  parameter int T_START_NS  = 100000,
  parameter int T_CHIRP_NS  = 1500000,
  parameter int T_KJ_NS     = 2500,
  parameter int T_JDEB_NS   = 100000,
  parameter int T_REVERT_NS = 3050000,
  parameter int T_RESAMP_NS = 300000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_st,
  output logic       term_hs,
  output logic       hs_en,
  output logic       tx_chirp_k,
  output logic       fs_fallback
);

  function automatic int cyc(input int ns);
    longint p;
    p = (longint'(ns) * longint'(CLK_MHZ) + longint'(999)) / longint'(1000);
    if (p < longint'(1)) p = longint'(1);
    return int'(p);
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_DET    = cyc(T_DET_NS);
  localparam int C_START  = cyc(T_START_NS);
  localparam int C_CHIRP  = cyc(T_CHIRP_NS);
  localparam int C_KJ     = cyc(T_KJ_NS);
  localparam int C_JDEB   = cyc(T_JDEB_NS);
  localparam int C_REVERT = cyc(T_REVERT_NS);
  localparam int C_RESAMP = cyc(T_RESAMP_NS);
  localparam int C_MAX    = mx(mx(mx(C_CHIRP, C_REVERT), mx(C_START, C_RESAMP)),
                               mx(C_JDEB, mx(C_DET, C_KJ)));
  localparam int CW       = $clog2(C_MAX + 1) + 1;

  localparam logic [CW-1:0] SAT      = '1;
  localparam logic [CW-1:0] M_DET    = CW'(C_DET - 1);
  localparam logic [CW-1:0] M_START  = CW'(C_START - 1);
  localparam logic [CW-1:0] M_CHIRP  = CW'(C_CHIRP - 1);
  localparam logic [CW-1:0] M_KJ     = CW'(C_KJ - 1);
  localparam logic [CW-1:0] M_JDEB   = CW'(C_JDEB - 1);
  localparam logic [CW-1:0] M_REVERT = CW'(C_REVERT - 1);
  localparam logic [CW-1:0] M_RESAMP = CW'(C_RESAMP - 1);
  localparam logic [CW-1:0] N_CHIRP  = CW'(C_CHIRP);

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;

  typedef enum logic [2:0] {
    ST_FS_IDLE, ST_RST_WAIT, ST_CHIRP, ST_LISTEN, ST_HS, ST_REVERT
  } st_t;

  st_t           state, st_n;
  logic [1:0]    line_q;
  logic [CW-1:0] hold, st_cnt;
  logic [2:0]    kj_cnt;
  logic          fb_q;

  wire       chg     = line_st != line_q;
  wire       se0_det = (line_q == LS_SE0) && (hold >= M_DET);
  wire       se0_rev = (line_q == LS_SE0) && (hold >= M_REVERT);
  wire       j_long  = (line_q == LS_J) && (hold >= M_JDEB);
  wire [1:0] exp_lvl = kj_cnt[0] ? LS_J : LS_K;
  wire       kj_ok   = chg && (line_q == exp_lvl) && (hold >= M_KJ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= LS_J;
      hold   <= '0;
    end else begin
      line_q <= line_st;
      hold   <= chg ? '0 : (hold == SAT) ? hold : hold + 1'b1;
    end
  end

  always_comb begin
    st_n = state;
    unique case (state)
      ST_FS_IDLE:  if (se0_det) st_n = ST_RST_WAIT;
      ST_RST_WAIT: if (j_long) st_n = ST_FS_IDLE;
                   else if (st_cnt == M_START) st_n = ST_CHIRP;
      ST_CHIRP:    if (st_cnt == M_CHIRP) st_n = ST_LISTEN;
      ST_LISTEN:   if (j_long) st_n = ST_FS_IDLE;
                   else if (kj_ok && kj_cnt == 3'd5) st_n = ST_HS;
      ST_HS:       if (se0_rev) st_n = ST_REVERT;
      ST_REVERT:   if (st_cnt == M_RESAMP)
                     st_n = (line_st == LS_SE0) ? ST_CHIRP : ST_FS_IDLE;
      default:     st_n = ST_FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_FS_IDLE;
      st_cnt <= '0;
      kj_cnt <= '0;
      fb_q   <= 1'b0;
    end else begin
      state  <= st_n;
      st_cnt <= (st_n != state) ? '0 : (st_cnt == SAT) ? st_cnt : st_cnt + 1'b1;
      if (state != ST_LISTEN) kj_cnt <= '0;
      else if (chg)           kj_cnt <= kj_ok ? kj_cnt + 3'd1 : 3'd0;
      if (state == ST_LISTEN && st_n == ST_FS_IDLE)
        fb_q <= 1'b1;
      else if (st_n == ST_RST_WAIT || (state == ST_REVERT && st_n == ST_CHIRP))
        fb_q <= 1'b0;
    end
  end

  assign term_hs     = state == ST_HS;
  assign hs_en       = state == ST_HS;
  assign tx_chirp_k  = state == ST_CHIRP;
  assign fs_fallback = fb_q;

  logic [CW-1:0] ast_k_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ast_k_len <= '0;
    else        ast_k_len <= !tx_chirp_k ? '0 : (ast_k_len == SAT) ? ast_k_len : ast_k_len + 1'b1;
  end

  AST_CHIRP_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_chirp_k) |-> ast_k_len >= N_CHIRP); // R3
  AST_HS_FROM_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> $past(state) == ST_LISTEN); // R4
  AST_FALLBACK_ON_J: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_fallback) |-> !hs_en && $past(line_q) == LS_J); // R6
  AST_REVERT_ON_SE0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en) |-> $past(line_q) == LS_SE0); // R7
  AST_ACTIVITY_KEEPS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && line_q != LS_SE0) |=> hs_en); // R8
  AST_RESAMPLE_SE0: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHIRP && $past(state) == ST_REVERT) |-> $past(line_st) == LS_SE0); // R9

endmodule

// File: tb/test_hs_chirp_seq.sv
module test_hs_chirp_seq;

  localparam logic [1:0] SE0 = 2'b00, LJ = 2'b01, LK = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] line;
  logic       term_hs, hs_en, tx_chirp_k, fs_fallback;
  int         errs = 0, checks = 0;
  bit         finished = 0;

  always #2.5 clk = ~clk;

  // Time base of one cycle per microsecond keeps millisecond windows short.
  hs_chirp_seq #(.CLK_MHZ(1)) i_hs_chirp_seq (
    .clk(clk), .rst_n(rst_n), .line_st(line),
    .term_hs(term_hs), .hs_en(hs_en), .tx_chirp_k(tx_chirp_k), .fs_fallback(fs_fallback)
  );

  typedef struct packed {
    logic       from_hs;
    logic       rs_se0;
    logic [3:0] n_st;
    logic [7:0] st_len;
    logic       exp_hs;
    logic       exp_fb;
  } scn_t;

  localparam scn_t SCN [0:7] = '{
    '{1'b0, 1'b1, 4'd5, 8'd40, 1'b0, 1'b1},
    '{1'b0, 1'b1, 4'd6, 8'd2,  1'b0, 1'b1},
    '{1'b0, 1'b1, 4'd6, 8'd40, 1'b1, 1'b0},
    '{1'b1, 1'b1, 4'd7, 8'd3,  1'b1, 1'b0},
    '{1'b1, 1'b0, 4'd0, 8'd0,  1'b0, 1'b0},
    '{1'b0, 1'b1, 4'd6, 8'd10, 1'b1, 1'b0},
    '{1'b1, 1'b1, 4'd4, 8'd40, 1'b0, 1'b1},
    '{1'b0, 1'b1, 4'd6, 8'd3,  1'b1, 1'b0}
  };

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic run_scn(input scn_t s);
    int t, rst_t, k, hs_at, q_at;
    bit seen;
    if (!s.from_hs) begin
      line = LJ;
      repeat (20) @(negedge clk);
      line = SE0;
      t = 0;
      while (!tx_chirp_k && t < 8000) begin @(negedge clk); t++; end
      chk_rng("R2 chirp start after SE0", t, 3, 6000);
      chk_eq("R6 fallback cleared by new reset", fs_fallback, 0);
      rst_t = t;
    end else begin
      chk_eq("R8 in HS before run", hs_en, 1);
      for (int b = 0; b < 3; b++) begin
        line = SE0; repeat (2000) @(negedge clk);
        line = LK;  repeat (5) @(negedge clk);
        line = LJ;  repeat (5) @(negedge clk);
        chk_eq("R8 activity keeps HS", hs_en, 1);
      end
      line = SE0;
      t = 0;
      while (term_hs && t < 4000) begin @(negedge clk); t++; end
      chk_rng("R7 revert time", t, 3000, 3125);
      chk_eq("R7 hs_en dropped", hs_en, 0);
      rst_t = t;
      if (!s.rs_se0) begin
        line = LJ;
        seen = 0;
        repeat (1000) begin @(negedge clk); if (tx_chirp_k || hs_en) seen = 1; end
        chk_eq("R10 no chirp on suspend", seen, 0);
        chk_eq("R10 term_hs", term_hs, 0);
        chk_eq("R10 fallback", fs_fallback, 0);
        return;
      end
      t = 0;
      while (!tx_chirp_k && t < 1000) begin @(negedge clk); t++; end
      chk_rng("R9 resample to chirp", t, 100, 875);
      rst_t += t;
    end
    t = 0;
    while (tx_chirp_k && t < 8000) begin @(negedge clk); t++; end
    chk_rng("R3 chirp length", t, 1000, 7000);
    chk_rng("R3 chirp end from reset", rst_t + t, 0, 7000);
    repeat (10) @(negedge clk);
    k = 0; hs_at = -1; q_at = -1;
    for (int n = 0; n < int'(s.n_st); n++) begin
      line = n[0] ? LJ : LK;
      repeat (int'(s.st_len)) begin
        @(negedge clk); k++;
        if (hs_en && hs_at < 0) hs_at = k;
      end
      if (n == 5) q_at = k;
    end
    if (s.exp_hs) begin
      line = SE0;
      repeat (600) begin @(negedge clk); k++; if (hs_en && hs_at < 0) hs_at = k; end
      chk_rng("R4 HS entry delay", hs_at - q_at, 0, 500);
      chk_eq("R4 term_hs", term_hs, 1);
      chk_eq("R4 fallback", fs_fallback, 0);
    end else begin
      line = LJ;
      repeat (150) begin @(negedge clk); if (hs_en && hs_at < 0) hs_at = 1; end
      chk_eq("R5 no HS on bad answer", hs_at < 0, 1);
      chk_eq("R6 fallback flag", fs_fallback, int'(s.exp_fb));
      chk_eq("R6 term_hs", term_hs, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    bit seen;
    rst_n = 1'b0;
    line = LJ;
    repeat (5) @(negedge clk);
    chk_eq("R1 reset term_hs", term_hs, 0);
    chk_eq("R1 reset hs_en", hs_en, 0);
    chk_eq("R1 reset tx", tx_chirp_k, 0);
    chk_eq("R1 reset fallback", fs_fallback, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < 8; i++) run_scn(SCN[i]);

    rst_n = 1'b0;
    @(negedge clk);
    chk_eq("R1 reset from HS hs_en", hs_en, 0);
    chk_eq("R1 reset from HS term", term_hs, 0);
    rst_n = 1'b1;

    line = LJ; repeat (20) @(negedge clk);
    line = SE0; repeat (2) @(negedge clk);
    line = LJ;
    seen = 0;
    repeat (300) begin @(negedge clk); if (tx_chirp_k) seen = 1; end
    chk_eq("R11 short SE0 ignored", seen, 0);

    line = SE0;
    for (int t = 0; t < 8000 && !tx_chirp_k; t++) @(negedge clk);
    chk_eq("R2 chirp before reset test", tx_chirp_k, 1);
    rst_n = 1'b0;
    #1;
    chk_eq("R1 reset during chirp", tx_chirp_k, 0);
    @(negedge clk);
    line = LJ;
    rst_n = 1'b1;
    seen = 0;
    repeat (200) begin @(negedge clk); if (tx_chirp_k) seen = 1; end
    chk_eq("R1 idle after reset", seen, 0);

    summary();
  end

endmodule